// File: doc/BRIEF.md
# Interruptible Block-Transfer Sequencer

This block steps through one load-multiple or store-multiple instruction. It takes a 16-bit register mask, a base address, an addressing mode (increment-after or decrement-before) and a writeback flag. It then issues one word access per clock to a simple memory port, always accepted in the same cycle. The lowest-numbered register in the mask uses the lowest address. The block does not handle the register data itself: each access names the register it belongs to on `mem_reg`, and the register file does the data path.

While the block is running it can be stopped. A synchronous data abort that arrives with an access stops the instruction in every configuration. An interrupt (IRQ or FIQ) or an asynchronous abort can also stop it, but only in low-latency mode, and only at a boundary between two word accesses. A stopped instruction ends in one of two ways. It is abandoned and must later be issued again from its first word, so a store may write its lower words twice. Or, when resuming is allowed and the instruction can be continued, it is suspended and reports the index of the next register. Issuing the instruction again with that index skips the registers already moved. A load whose list contains the stack pointer (register 13) can never be continued.

The base register is only updated after the last word completes, and the block reports that update as a writeback value.

Top module: `lsm_seq`

## Requirements
- R1: Accesses go in ascending register order, one per cycle, at consecutive word addresses (step 4). The first address is the base in increment-after mode (`op_dec_before`=0). It is base minus 4 times the number of set mask bits in decrement-before mode (`op_dec_before`=1). `mem_we` is 1 for a store and 0 for a load (`op_load`=1).
- R2: When an instruction with `op_writeback`=1 completes, `wb_en` pulses in the same cycle as `done`. `wb_val` then equals base minus 4·count in decrement-before mode, or base plus 4·count in increment-after mode. `wb_en` never rises on an abandon or a suspend.
- R3: With `cfg_low_lat`=0, `irq`, `fiq` and `async_abt` have no effect: the transfer runs to completion.
- R4: With `cfg_low_lat`=1, if `irq`, `fiq` or `async_abt` is high during an access that is not the last one, that access completes and no further access is issued.
- R5: A stop under R4 with `cfg_resume_ok`=0 raises `abandon` in the cycle after the last completed access.
- R6: A stop under R4 with `cfg_resume_ok`=1 on a continuable instruction raises `suspend` instead. `susp_idx` then gives the number of the next register in the mask.
- R7: A load whose mask has bit 13 set is non-continuable: a stop under R4 abandons it even when `cfg_resume_ok`=1. The same list as a store still suspends.
- R8: In any mode, `data_abort` high during an access abandons the instruction, even on the last access, with no writeback. The data abort takes priority over a pending interrupt.
- R9: A start with `op_resume`=1 skips the mask bits below `op_resume_idx`. The remaining accesses use the same addresses as an uninterrupted run. If no set bit remains, the instruction completes with no access.
- R10: `done`, `abandon` and `suspend` are mutually exclusive, and each one is high for exactly one cycle.
- R11: An empty mask completes (`done`) in the cycle after the start, with no memory access. Its writeback value is the unchanged base.
- R12: A `start` while `busy` is high is ignored: the running transfer continues unchanged.
- R13: After reset, `busy`, `mem_req`, `done`, `abandon`, `suspend` and `wb_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_low_lat | input | 1 | 1 = interrupts and asynchronous aborts may stop a transfer |
| cfg_resume_ok | input | 1 | 1 = a stopped continuable transfer is suspended, not abandoned |
| start | input | 1 | Accept the instruction on the op_* inputs (when idle) |
| op_load | input | 1 | 1 = load-multiple, 0 = store-multiple |
| op_dec_before | input | 1 | 1 = decrement-before, 0 = increment-after |
| op_writeback | input | 1 | Update the base when the instruction completes |
| op_mask | input | 16 | Register list, bit n = register n |
| op_base | input | 32 | Base address |
| op_resume | input | 1 | Continue a suspended instruction |
| op_resume_idx | input | 4 | Register index to continue from |
| irq | input | 1 | Normal interrupt request |
| fiq | input | 1 | Fast interrupt request |
| async_abt | input | 1 | Asynchronous abort |
| data_abort | input | 1 | Synchronous abort of the current access |
| mem_req | output | 1 | Word access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_reg | output | 4 | Register number of this access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Instruction completed (one-cycle strobe) |
| abandon | output | 1 | Instruction abandoned (one-cycle strobe) |
| suspend | output | 1 | Instruction suspended (one-cycle strobe) |
| susp_idx | output | 4 | Next register to transfer after a suspend |
| wb_en | output | 1 | Base writeback strobe |
| wb_val | output | 32 | New base value |

## Verification
The bench builds the block with its default parameters: sixteen registers, 32-bit addresses, 4-byte words and register 13 as the stack pointer. With those values it can use the full-width mask 0x8001, masks with and without bit 13 for the continuable/non-continuable split, and decrement-before addresses that fall below the base. It stops transfers on the first, a middle and the last access, so it covers both a stop at a word boundary and a stop on the final word, where nothing remains. It also covers resume indices both inside and beyond the set bits of the mask.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int LSM_NREG       = 16;
    localparam int LSM_AW         = 32;
    localparam int LSM_WORD_BYTES = 4;
    localparam int LSM_SP         = 13;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lsm_state_e;

    typedef enum logic [1:0] {
        END_NONE    = 2'd0,
        END_DONE    = 2'd1,
        END_ABANDON = 2'd2,
        END_SUSPEND = 2'd3
    } lsm_end_e;

    // Outcome of the access in flight this cycle.
    function automatic lsm_end_e lsm_decide(
        input logic active,
        input logic sync_abort,
        input logic last_word,
        input logic low_lat,
        input logic resume_ok,
        input logic pending,
        input logic continuable
    );
        if (!active)             return END_NONE;
        if (sync_abort)          return END_ABANDON;
        if (last_word)           return END_DONE;
        if (low_lat && pending)  return (resume_ok && continuable) ? END_SUSPEND : END_ABANDON;
        return END_NONE;
    endfunction

endpackage

// File: rtl/lsm_ptr_find.sv
module lsm_ptr_find #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    input  logic [IW:0]     from,
    output logic            found,
    output logic [IW-1:0]   idx
);

    // Lowest set bit at or above "from"; descending scan so the lowest wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i] && ((IW+1)'(i) >= from)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    input  logic            dec_before,
    input  logic [AW-1:0]   base,
    input  logic [IW-1:0]   ptr,
    output logic [AW-1:0]   acc_addr,
    output logic [AW-1:0]   wb_val
);

    localparam int CW = IW + 1;

    logic [CW-1:0] total;
    logic [CW-1:0] below;
    logic [AW-1:0] span;
    logic [AW-1:0] first;

    always_comb begin
        total = '0;
        below = '0;
        for (int i = 0; i < NREG; i++) begin
            if (mask[i]) begin
                total = total + 1'b1;
                if (IW'(i) < ptr) begin
                    below = below + 1'b1;
                end
            end
        end
    end

    assign span     = AW'(total) * AW'(WB);
    assign first    = dec_before ? (base - span) : base;
    assign wb_val   = dec_before ? (base - span) : (base + span);
    assign acc_addr = first + AW'(below) * AW'(WB);

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int NREG   = LSM_NREG,
    parameter int AW     = LSM_AW,
    parameter int WB     = LSM_WORD_BYTES,
    parameter int SP_IDX = LSM_SP,
    localparam int IW    = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_low_lat,
    input  logic            cfg_resume_ok,
    input  logic            start,
    input  logic            op_load,
    input  logic            op_dec_before,
    input  logic            op_writeback,
    input  logic [NREG-1:0] op_mask,
    input  logic [AW-1:0]   op_base,
    input  logic            op_resume,
    input  logic [IW-1:0]   op_resume_idx,
    input  logic            irq,
    input  logic            fiq,
    input  logic            async_abt,
    input  logic            data_abort,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [IW-1:0]   mem_reg,
    output logic            busy,
    output logic            done,
    output logic            abandon,
    output logic            suspend,
    output logic [IW-1:0]   susp_idx,
    output logic            wb_en,
    output logic [AW-1:0]   wb_val
);

    lsm_state_e      state_q;
    logic            ld_q, dec_q, wbk_q;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   base_q;
    logic [IW-1:0]   ptr_q;
    logic            done_q, abandon_q, suspend_q, wb_en_q;
    logic [IW-1:0]   susp_idx_q;

    logic [IW:0]     st_from, nx_from;
    logic            st_found, nx_found;
    logic [IW-1:0]   st_idx, nx_idx;
    logic            continuable, pending;
    lsm_end_e        end_c;

    assign st_from = op_resume ? {1'b0, op_resume_idx} : '0;
    assign nx_from = {1'b0, ptr_q} + 1'b1;

    lsm_ptr_find #(.NREG(NREG), .IW(IW)) u_first (
        .mask  (op_mask),
        .from  (st_from),
        .found (st_found),
        .idx   (st_idx)
    );

    lsm_ptr_find #(.NREG(NREG), .IW(IW)) u_next (
        .mask  (mask_q),
        .from  (nx_from),
        .found (nx_found),
        .idx   (nx_idx)
    );

    lsm_addr_gen #(.NREG(NREG), .AW(AW), .WB(WB), .IW(IW)) u_addr (
        .mask       (mask_q),
        .dec_before (dec_q),
        .base       (base_q),
        .ptr        (ptr_q),
        .acc_addr   (mem_addr),
        .wb_val     (wb_val)
    );

    assign continuable = !(ld_q && mask_q[SP_IDX]);
    assign pending     = irq | fiq | async_abt;
    assign end_c       = lsm_decide(state_q == ST_RUN, data_abort, !nx_found,
                                    cfg_low_lat, cfg_resume_ok, pending, continuable);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ld_q       <= 1'b0;
            dec_q      <= 1'b0;
            wbk_q      <= 1'b0;
            mask_q     <= '0;
            base_q     <= '0;
            ptr_q      <= '0;
            done_q     <= 1'b0;
            abandon_q  <= 1'b0;
            suspend_q  <= 1'b0;
            wb_en_q    <= 1'b0;
            susp_idx_q <= '0;
        end else begin
            done_q    <= 1'b0;
            abandon_q <= 1'b0;
            suspend_q <= 1'b0;
            wb_en_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ld_q   <= op_load;
                        dec_q  <= op_dec_before;
                        wbk_q  <= op_writeback;
                        mask_q <= op_mask;
                        base_q <= op_base;
                        if (st_found) begin
                            state_q <= ST_RUN;
                            ptr_q   <= st_idx;
                        end else begin
                            done_q  <= 1'b1;
                            wb_en_q <= op_writeback;
                        end
                    end
                end
                ST_RUN: begin
                    unique case (end_c)
                        END_DONE: begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            wb_en_q <= wbk_q;
                        end
                        END_ABANDON: begin
                            state_q   <= ST_IDLE;
                            abandon_q <= 1'b1;
                        end
                        END_SUSPEND: begin
                            state_q    <= ST_IDLE;
                            suspend_q  <= 1'b1;
                            susp_idx_q <= nx_idx;
                        end
                        END_NONE: begin
                            ptr_q <= nx_idx;
                        end
                    endcase
                end
            endcase
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign mem_req  = busy;
    assign mem_we   = !ld_q;
    assign mem_reg  = ptr_q;
    assign done     = done_q;
    assign abandon  = abandon_q;
    assign suspend  = suspend_q;
    assign wb_en    = wb_en_q;
    assign susp_idx = susp_idx_q;

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
    parameter int AW = 32,
    parameter int WB = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_low_lat,
    input logic          irq,
    input logic          fiq,
    input logic          async_abt,
    input logic          data_abort,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          abandon,
    input logic          suspend,
    input logic          wb_en
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_step_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (past_ok && mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + AW'(WB)));

    assert_wb_with_done_R2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    assert_std_holds_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_low_lat && mem_req && !data_abort) |=> (mem_req || done));

    assert_ll_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_low_lat && mem_req && (irq || fiq || async_abt)) |=> !mem_req);

    assert_dabort_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && data_abort) |=> (abandon && !wb_en));

    assert_one_end_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, abandon, suspend}));

    assert_abandon_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        abandon |=> !abandon);

    assert_suspend_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        suspend |=> !suspend);

endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .WB(WB)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_low_lat (cfg_low_lat),
    .irq         (irq),
    .fiq         (fiq),
    .async_abt   (async_abt),
    .data_abort  (data_abort),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .done        (done),
    .abandon     (abandon),
    .suspend     (suspend),
    .wb_en       (wb_en)
);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;

    localparam logic [31:0] BASE = 32'h0000_1000;

    typedef struct packed {
        logic [15:0]       mask;
        logic              dec;
        logic              load;
        logic              wb;
        logic              ll;
        logic              ro;
        logic signed [7:0] int_at;
        logic [1:0]        kind;    // 0 irq, 1 fiq, 2 async abort
        logic signed [7:0] dab_at;
        logic [1:0]        outc;    // 1 done, 2 abandon, 3 suspend
        logic [4:0]        n;
        logic [3:0]        idx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h00F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,  8'sd1, 2'd0, -8'sd1, 2'd1, 5'd4, 4'd0}, // R3
        '{16'h01FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,  8'sd1, 2'd0, -8'sd1, 2'd2, 5'd2, 4'd0}, // R5
        '{16'h01FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,  8'sd1, 2'd0, -8'sd1, 2'd3, 5'd2, 4'd2}, // R6
        '{16'h2003, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,  8'sd0, 2'd0, -8'sd1, 2'd2, 5'd1, 4'd0}, // R7 load
        '{16'h2003, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  8'sd0, 2'd0, -8'sd1, 2'd3, 5'd1, 4'd1}, // R7 store
        '{16'h8001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, -8'sd1, 2'd0,  8'sd1, 2'd2, 5'd2, 4'd0}, // R8 last
        '{16'h0005, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, -8'sd1, 2'd0, -8'sd1, 2'd1, 5'd2, 4'd0}, // R1 R2
        '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -8'sd1, 2'd0, -8'sd1, 2'd1, 5'd0, 4'd0}, // R11
        '{16'h00F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  8'sd3, 2'd0, -8'sd1, 2'd1, 5'd4, 4'd0}, // R4 last
        '{16'h0003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,  8'sd0, 2'd2, -8'sd1, 2'd2, 5'd1, 4'd0}, // R4 async
        '{16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,  8'sd0, 2'd1,  8'sd0, 2'd2, 5'd1, 4'd0}, // R8 std
        '{16'h0007, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,  8'sd1, 2'd1, -8'sd1, 2'd3, 5'd2, 4'd2}, // R6 fiq
        '{16'h0003, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,  8'sd0, 2'd0,  8'sd0, 2'd2, 5'd1, 4'd0}  // R8 prio
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_low_lat = 1'b0, cfg_resume_ok = 1'b0;
    logic        start = 1'b0, op_load = 1'b0, op_dec_before = 1'b0, op_writeback = 1'b0;
    logic [15:0] op_mask = '0;
    logic [31:0] op_base = '0;
    logic        op_resume = 1'b0;
    logic [3:0]  op_resume_idx = '0;
    logic        irq = 1'b0, fiq = 1'b0, async_abt = 1'b0, data_abort = 1'b0;
    logic        mem_req, mem_we, busy, done, abandon, suspend, wb_en;
    logic [31:0] mem_addr, wb_val;
    logic [3:0]  mem_reg, susp_idx;

    int checks = 0;
    int errors = 0;

    logic [31:0] rec_addr [32];
    logic [3:0]  rec_reg  [32];
    logic        rec_we   [32];

    always #4 clk = ~clk;

    lsm_seq u_dut (
        .clk(clk), .rst(rst), .cfg_low_lat(cfg_low_lat), .cfg_resume_ok(cfg_resume_ok),
        .start(start), .op_load(op_load), .op_dec_before(op_dec_before),
        .op_writeback(op_writeback), .op_mask(op_mask), .op_base(op_base),
        .op_resume(op_resume), .op_resume_idx(op_resume_idx),
        .irq(irq), .fiq(fiq), .async_abt(async_abt), .data_abort(data_abort),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_reg(mem_reg),
        .busy(busy), .done(done), .abandon(abandon), .suspend(suspend),
        .susp_idx(susp_idx), .wb_en(wb_en), .wb_val(wb_val)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic logic [31:0] exp_wb(input logic [15:0] m, input logic dec);
        logic [31:0] span = 32'(popc(m)) * 32'd4;
        return dec ? BASE - span : BASE + span;
    endfunction

    task automatic run_op(input logic [15:0] mask, input logic dec, input logic load,
                          input logic wb, input logic ll, input logic ro,
                          input logic res, input logic [3:0] ridx,
                          input int int_at, input int kind, input int dab_at,
                          output int outc, output int n, output logic wbe,
                          output logic [31:0] wbv, output logic [3:0] sidx);
        @(negedge clk);
        cfg_low_lat = ll; cfg_resume_ok = ro;
        op_mask = mask; op_dec_before = dec; op_load = load; op_writeback = wb;
        op_base = BASE; op_resume = res; op_resume_idx = ridx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; outc = 0; wbe = 1'b0; wbv = '0; sidx = '0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            irq = 1'b0; fiq = 1'b0; async_abt = 1'b0; data_abort = 1'b0;
            if (done || abandon || suspend) begin
                outc = done ? 1 : (abandon ? 2 : 3);
                wbe = wb_en; wbv = wb_val; sidx = susp_idx;
                break;
            end
            if (mem_req) begin
                rec_addr[n] = mem_addr; rec_reg[n] = mem_reg; rec_we[n] = mem_we;
                if (n == int_at) begin
                    irq = (kind == 0); fiq = (kind == 1); async_abt = (kind == 2);
                end
                if (n == dab_at) data_abort = 1'b1;
                n++;
            end
            @(negedge clk);
        end
        irq = 1'b0; fiq = 1'b0; async_abt = 1'b0; data_abort = 1'b0;
        @(negedge clk);
        chk(!done && !abandon && !suspend && !wb_en && !mem_req, "R10 strobe width",
            {28'd0, done, abandon, suspend, wb_en}, 32'd0);
    endtask

    task automatic check_acc(input logic [15:0] mask, input logic dec, input logic load,
                             input logic res, input logic [3:0] ridx, input int n, input string tag);
        logic [31:0] first = dec ? BASE - 32'(popc(mask)) * 32'd4 : BASE;
        int rank = 0;
        int j = 0;
        for (int i = 0; i < 16; i++) begin
            if (mask[i]) begin
                if ((!res || i >= int'(ridx)) && j < n) begin
                    chk(rec_addr[j] == first + 32'(rank) * 32'd4, {tag, " R1 addr"}, rec_addr[j], first + 32'(rank) * 32'd4);
                    chk(rec_reg[j] == 4'(i), {tag, " R1 reg"}, 32'(rec_reg[j]), 32'(i));
                    chk(rec_we[j] == !load, {tag, " R1 we"}, 32'(rec_we[j]), 32'(!load));
                    j++;
                end
                rank++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int outc, n;
        logic wbe;
        logic [31:0] wbv;
        logic [3:0] sidx;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(!busy && !mem_req && !done && !abandon && !suspend && !wb_en, "R13 reset",
            {26'd0, busy, mem_req, done, abandon, suspend, wb_en}, 32'd0);

        // Table walk: R1..R8, R11
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            string tag = $sformatf("vec%0d", v);
            run_op(t.mask, t.dec, t.load, t.wb, t.ll, t.ro, 1'b0, 4'd0,
                   int'(t.int_at), int'(t.kind), int'(t.dab_at), outc, n, wbe, wbv, sidx);
            chk(outc == int'(t.outc), {tag, " R4/R5/R6/R7/R8 outcome"}, 32'(outc), 32'(t.outc));
            chk(n == int'(t.n), {tag, " R3/R4 access count"}, 32'(n), 32'(t.n));
            check_acc(t.mask, t.dec, t.load, 1'b0, 4'd0, n, tag);
            chk(wbe == (t.wb && t.outc == 2'd1), {tag, " R2 wb_en"}, 32'(wbe), 32'(t.wb && t.outc == 2'd1));
            if (wbe) chk(wbv == exp_wb(t.mask, t.dec), {tag, " R2 wb_val"}, wbv, exp_wb(t.mask, t.dec));
            if (t.outc == 2'd3) chk(sidx == t.idx, {tag, " R6 susp_idx"}, 32'(sidx), 32'(t.idx));
        end

        // R9 resume from register 2, decrement-before store
        run_op(16'h01FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, -1, 0, -1, outc, n, wbe, wbv, sidx);
        chk(outc == 1, "R9 resume outcome", 32'(outc), 32'd1);
        chk(n == 7, "R9 resume count", 32'(n), 32'd7);
        check_acc(16'h01FF, 1'b1, 1'b0, 1'b1, 4'd2, n, "R9 resume");
        chk(wbe && wbv == 32'h0000_0FDC, "R9 resume wb", wbv, 32'h0000_0FDC);

        // R9 resume index beyond the last set bit
        run_op(16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, -1, 0, -1, outc, n, wbe, wbv, sidx);
        chk(outc == 1 && n == 0, "R9 resume past end", 32'(n), 32'd0);

        // R12 start while busy is ignored
        @(negedge clk);
        cfg_low_lat = 1'b0; cfg_resume_ok = 1'b0; op_resume = 1'b0;
        op_mask = 16'h000F; op_dec_before = 1'b0; op_load = 1'b0; op_writeback = 1'b0;
        op_base = BASE; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; outc = 0;
        for (int cyc = 0; cyc < 20; cyc++) begin
            start = 1'b0;
            if (done) begin outc = 1; break; end
            if (mem_req) begin
                rec_addr[n] = mem_addr; rec_reg[n] = mem_reg; rec_we[n] = mem_we;
                n++;
            end
            if (cyc == 0) begin
                op_mask = 16'h00F0; start = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(outc == 1 && n == 4, "R12 busy start count", 32'(n), 32'd4);
        check_acc(16'h000F, 1'b0, 1'b0, 1'b0, 4'd0, n, "R12");
        @(negedge clk);
        chk(!busy, "R12 idle after", 32'(busy), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule